// File: doc/BRIEF.md
# Internal Data Memory Address Decoder

This block sits between an 8-bit controller core and its on-chip data storage. Every data-space access from the core arrives with an 8-bit address, a flag telling whether the address was reached directly or through a pointer, and a kind code. The kind code says whether the access is a whole byte, a single bit, or a working-register operand. The block steers the access to a 256-byte RAM it contains, to a small internal status register, or to an external special-register bus.

In the upper half of the address range the addressing mode picks the target. Direct accesses reach the special registers, and pointer accesses (stack traffic included) reach the upper RAM. Register operands are mapped into one of four eight-byte banks. The status register chooses the bank. Bit operands are mapped onto a bit-addressable RAM area or onto aligned special registers. Bit writes are read-modify-write operations.

All writes are committed one cycle after they are issued. A forwarding path means the next access always sees the newest value, and that includes the bank choice.

Top module: `idm_decoder`

## Requirements
- R1: A byte access (kind 2'b00) with address 00h–7Fh reaches the RAM byte at that address whether `acc_indirect` is 0 or 1, and never touches the special-register bus.
- R2: A byte access with address 80h–FFh goes to the special-register space when `acc_indirect`=0 and to RAM byte 80h–FFh when `acc_indirect`=1. A special-register write leaves the RAM byte of the same number unchanged, and the reverse also holds.
- R3: A register access (kind 2'b10) uses RAM address {bank[1:0], acc_addr[2:0]}. The bank is bits 4:3 of the internal status register, which sits at direct address D0h and never appears on the external special-register bus.
- R4: After reset the status register is 00h, so `bank_sel`=0 and bank 0 is used, and `acc_rvalid` is 0.
- R5: A bit access (kind 2'b01) with address b below 80h targets RAM byte 20h+b[6:3], bit b[2:0]. A bit read returns that bit in `acc_rdata[0]` with bits 7:1 zero. A bit write stores `acc_wdata[0]` there and keeps the other seven bits.
- R6: A bit access with address b of 80h or above targets special register {b[7:3],3'b000}, bit b[2:0]. The read-modify-write goes over the external bus, or through the status register when the byte is D0h.
- R7: Read data appears on `acc_rdata` with `acc_rvalid`=1 one cycle after `acc_rd`. A write is committed (`ram_we` or `sfr_wr`) one cycle after `acc_wr`. An access in the cycle right after a write to the same byte sees the written value, and this holds for chained bit writes too.
- R8: A write to the status register changes the bank used by a register access issued in the very next cycle.
- R9: Kind code 2'b11 is ignored. It raises no select, no strobe and no `acc_rvalid`, and it changes no stored byte.
- R10: A read of an external special register returns `sfr_rdata` unchanged. The value is undefined for unimplemented addresses, and writes to those addresses have no effect on RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 8 | Access address, register number or bit address |
| acc_indirect | input | 1 | 1 = pointer (indirect) access, 0 = direct |
| acc_kind | input | 2 | 00 byte, 01 bit, 10 register, 11 none |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data (bit 0 for bit writes) |
| acc_rdata | output | 8 | Read data, registered |
| acc_rvalid | output | 1 | Read data valid |
| ram_sel | output | 1 | Current access targets RAM |
| sfr_sel | output | 1 | Current access targets special-register space |
| ram_we | output | 1 | RAM write-back enable |
| bank_sel | output | 2 | Effective register bank |
| sfr_raddr | output | 8 | External special-register read address |
| sfr_rd | output | 1 | External special-register read strobe |
| sfr_rdata | input | 8 | External special-register read data (same cycle) |
| sfr_waddr | output | 8 | External special-register write address |
| sfr_wr | output | 1 | External special-register write strobe |
| sfr_wdata | output | 8 | External special-register write data |

## Verification
The commit of one write and a new access to the same byte can happen in the same cycle. The same goes for the commit of a status-register write and a register access whose bank depends on it. The bench provokes both by issuing accesses back to back with no idle cycle: a byte write followed by a read, three bit writes into one byte followed by a byte read, and a bank change followed at once by a register write. Each case is judged by reading back the value that only a correct forward of the pending write would produce.

// File: rtl/idm_pkg.sv
// Package: shared widths, access kinds and the resolved-target record for
// the internal data memory decoder. Assumes an 8-bit data path.
package idm_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int BITSEL_W = 3;

    typedef enum logic [1:0] {
        K_BYTE = 2'b00,
        K_BIT  = 2'b01,
        K_REG  = 2'b10,
        K_NONE = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic                valid;
        logic                is_sfr;
        logic                is_bit;
        logic [ADDR_W-1:0]   byte_addr;
        logic [BITSEL_W-1:0] bit_idx;
    } tgt_t;

    // Replace one bit of a byte.
    function automatic logic [DATA_W-1:0] put_bit(input logic [DATA_W-1:0] b,
                                                  input logic [BITSEL_W-1:0] i,
                                                  input logic v);
        logic [DATA_W-1:0] r;
        r = b;
        r[i] = v;
        return r;
    endfunction
endpackage

// File: rtl/idm_map.sv
// Address translator: turns kind, mode, address and current bank into a
// physical target (RAM or special-register byte plus bit index).
// Purely combinational; assumes at most one access per cycle.
module idm_map #(
    parameter int                          REG_W    = 3,
    parameter int                          BANK_W   = 2,
    parameter logic [idm_pkg::ADDR_W-1:0]  BIT_BASE = 8'h20
) (
    input  logic [idm_pkg::ADDR_W-1:0] addr,
    input  logic                       indirect,
    input  logic [1:0]                 kind,
    input  logic                       active,
    input  logic [BANK_W-1:0]          bank,
    output idm_pkg::tgt_t              tgt
);
    import idm_pkg::*;

    localparam int PAD_W   = ADDR_W - REG_W - BANK_W;
    localparam int BYTE_IW = ADDR_W - 1 - BITSEL_W;

    logic upper;
    assign upper = addr[ADDR_W-1];

    // Resolve the target for the current access kind.
    always_comb begin
        tgt         = '0;
        tgt.valid   = active;
        tgt.bit_idx = addr[BITSEL_W-1:0];
        unique case (acc_kind_e'(kind))
            K_BYTE: begin
                tgt.is_sfr    = upper & ~indirect;
                tgt.byte_addr = addr;
            end
            K_REG: begin
                tgt.byte_addr = {{PAD_W{1'b0}}, bank, addr[REG_W-1:0]};
            end
            K_BIT: begin
                tgt.is_bit = 1'b1;
                if (upper) begin
                    tgt.is_sfr    = 1'b1;
                    tgt.byte_addr = {addr[ADDR_W-1:BITSEL_W], {BITSEL_W{1'b0}}};
                end else begin
                    tgt.byte_addr = BIT_BASE +
                        {{(ADDR_W-BYTE_IW){1'b0}}, addr[ADDR_W-2:BITSEL_W]};
                end
            end
            default: tgt.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/idm_ram.sv
// Internal data RAM: asynchronous read port, synchronous write port.
// Contents are not reset (undefined after reset).
module idm_ram #(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic [idm_pkg::ADDR_W-1:0] rd_addr,
    output logic [idm_pkg::DATA_W-1:0] rd_data,
    input  logic                       we,
    input  logic [idm_pkg::ADDR_W-1:0] wr_addr,
    input  logic [idm_pkg::DATA_W-1:0] wr_data
);
    import idm_pkg::*;

    logic [DATA_W-1:0] mem [DEPTH];

    // Combinational read.
    assign rd_data = mem[rd_addr];

    // Registered write.
    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/idm_psw_stub.sv
// Status register stub: holds the byte whose bits select the register bank.
// Resets to zero so that bank 0 is active.
module idm_psw_stub #(
    parameter int RS_LSB = 3,
    parameter int BANK_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [idm_pkg::DATA_W-1:0] wdata,
    output logic [idm_pkg::DATA_W-1:0] q,
    output logic [BANK_W-1:0]          bank
);
    import idm_pkg::*;

    // Hold the status byte.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    assign bank = q[RS_LSB +: BANK_W];
endmodule

// File: rtl/idm_decoder.sv
// Top: decodes core data accesses, reads in the request cycle, commits writes
// one cycle later and forwards the pending write (data and bank) to the next
// access. Assumes external special registers answer reads combinationally.
module idm_decoder #(
    parameter int                         RAM_DEPTH = 256,
    parameter int                         REG_W     = 3,
    parameter int                         BANK_W    = 2,
    parameter int                         RS_LSB    = 3,
    parameter logic [idm_pkg::ADDR_W-1:0] PSW_ADDR  = 8'hD0,
    parameter logic [idm_pkg::ADDR_W-1:0] BIT_BASE  = 8'h20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  acc_addr,
    input  logic        acc_indirect,
    input  logic [1:0]  acc_kind,
    input  logic        acc_rd,
    input  logic        acc_wr,
    input  logic [7:0]  acc_wdata,
    output logic [7:0]  acc_rdata,
    output logic        acc_rvalid,
    output logic        ram_sel,
    output logic        sfr_sel,
    output logic        ram_we,
    output logic [1:0]  bank_sel,
    output logic [7:0]  sfr_raddr,
    output logic        sfr_rd,
    input  logic [7:0]  sfr_rdata,
    output logic [7:0]  sfr_waddr,
    output logic        sfr_wr,
    output logic [7:0]  sfr_wdata
);
    import idm_pkg::*;

    // Pending write-back stage.
    logic              wb_valid;
    logic              wb_is_sfr;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;
    logic              wb_psw;
    logic              wb_ext;

    logic [DATA_W-1:0] psw_q;
    logic [BANK_W-1:0] psw_bank;
    logic [BANK_W-1:0] bank_eff;
    logic [DATA_W-1:0] ram_q;

    tgt_t              tgt;
    logic              active;
    logic              tgt_psw;
    logic              tgt_ext;
    logic              fwd_hit;
    logic [DATA_W-1:0] src_byte;
    logic [DATA_W-1:0] cur_byte;
    logic [DATA_W-1:0] new_byte;
    logic [DATA_W-1:0] rd_value;

    assign active = acc_rd | acc_wr;

    // Commit-side decode of the pending write.
    assign wb_psw = wb_valid & wb_is_sfr & (wb_addr == PSW_ADDR);
    assign wb_ext = wb_valid & wb_is_sfr & ~wb_psw;

    // Bank forwarding: a status write still pending already selects the bank.
    assign bank_eff = wb_psw ? wb_data[RS_LSB +: BANK_W] : psw_bank;
    assign bank_sel = bank_eff;

    idm_map #(
        .REG_W   (REG_W),
        .BANK_W  (BANK_W),
        .BIT_BASE(BIT_BASE)
    ) u_map (
        .addr    (acc_addr),
        .indirect(acc_indirect),
        .kind    (acc_kind),
        .active  (active),
        .bank    (bank_eff),
        .tgt     (tgt)
    );

    idm_ram #(
        .DEPTH(RAM_DEPTH)
    ) u_ram (
        .clk    (clk),
        .rd_addr(tgt.byte_addr),
        .rd_data(ram_q),
        .we     (ram_we),
        .wr_addr(wb_addr),
        .wr_data(wb_data)
    );

    idm_psw_stub #(
        .RS_LSB(RS_LSB),
        .BANK_W(BANK_W)
    ) u_psw (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wb_psw),
        .wdata(wb_data),
        .q    (psw_q),
        .bank (psw_bank)
    );

    // Target classification for the request cycle.
    assign tgt_psw = tgt.valid & tgt.is_sfr & (tgt.byte_addr == PSW_ADDR);
    assign tgt_ext = tgt.valid & tgt.is_sfr & ~tgt_psw;
    assign ram_sel = tgt.valid & ~tgt.is_sfr;
    assign sfr_sel = tgt.valid & tgt.is_sfr;

    // External read request: plain reads and the read half of a bit write.
    assign sfr_rd    = tgt_ext & (acc_rd | (acc_wr & tgt.is_bit));
    assign sfr_raddr = tgt_ext ? tgt.byte_addr : '0;

    // Pick the stored byte, then overlay a pending write to the same byte.
    always_comb begin
        if (tgt_psw)      src_byte = psw_q;
        else if (tgt_ext) src_byte = sfr_rdata;
        else              src_byte = ram_q;
        fwd_hit  = wb_valid & (wb_is_sfr == tgt.is_sfr) & (wb_addr == tgt.byte_addr);
        cur_byte = fwd_hit ? wb_data : src_byte;
    end

    // Build write data and read value from the current byte.
    always_comb begin
        if (tgt.is_bit) begin
            new_byte = put_bit(cur_byte, tgt.bit_idx, acc_wdata[0]);
            rd_value = {{(DATA_W-1){1'b0}}, cur_byte[tgt.bit_idx]};
        end else begin
            new_byte = acc_wdata;
            rd_value = cur_byte;
        end
    end

    // Register read results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rvalid <= 1'b0;
            acc_rdata  <= '0;
        end else begin
            acc_rvalid <= tgt.valid & acc_rd;
            if (tgt.valid & acc_rd) acc_rdata <= rd_value;
        end
    end

    // Capture a write into the write-back stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid  <= 1'b0;
            wb_is_sfr <= 1'b0;
            wb_addr   <= '0;
            wb_data   <= '0;
        end else begin
            wb_valid  <= tgt.valid & acc_wr;
            wb_is_sfr <= tgt.is_sfr;
            wb_addr   <= tgt.byte_addr;
            wb_data   <= new_byte;
        end
    end

    // Commit strobes.
    assign ram_we    = wb_valid & ~wb_is_sfr;
    assign sfr_wr    = wb_ext;
    assign sfr_waddr = wb_ext ? wb_addr : '0;
    assign sfr_wdata = wb_ext ? wb_data : '0;
endmodule

// File: rtl/idm_checker.sv
// Checker: timing and routing properties of the decoder, bound to the top.
module idm_checker #(
    parameter logic [7:0] PSW_ADDR = 8'hD0
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] acc_addr,
    input logic       acc_indirect,
    input logic [1:0] acc_kind,
    input logic       acc_rd,
    input logic       acc_wr,
    input logic       acc_rvalid,
    input logic       ram_sel,
    input logic       sfr_sel,
    input logic       ram_we,
    input logic [1:0] bank_sel,
    input logic [7:0] sfr_raddr,
    input logic       sfr_rd,
    input logic [7:0] sfr_waddr,
    input logic       sfr_wr
);
    logic act;
    assign act = acc_rd | acc_wr;

    AST_LOW_BYTE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (act && acc_kind == 2'b00 && !acc_addr[7]) |-> (ram_sel && !sfr_sel && !sfr_rd)); // R1
    AST_HIGH_DIRECT_SFR: assert property (@(posedge clk) disable iff (!rst_n)
        (act && acc_kind == 2'b00 && acc_addr[7] && !acc_indirect) |-> (sfr_sel && !ram_sel)); // R2
    AST_HIGH_INDIRECT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (act && acc_kind == 2'b00 && acc_addr[7] && acc_indirect) |-> (ram_sel && !sfr_rd)); // R2
    AST_STATUS_OFF_BUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rd |-> (sfr_raddr != PSW_ADDR)); // R3
    AST_STATUS_OFF_BUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |-> (sfr_waddr != PSW_ADDR)); // R3
    AST_BANK_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank_sel == 2'd0 && !acc_rvalid)); // R4
    AST_REG_IN_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (act && acc_kind == 2'b10) |-> (ram_sel && !sfr_rd)); // R3
    AST_BIT_SFR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (act && acc_kind == 2'b01 && acc_addr[7] && acc_addr[7:3] != PSW_ADDR[7:3])
            |-> (sfr_sel && sfr_rd && sfr_raddr == {acc_addr[7:3], 3'b000})); // R6
    AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rvalid |-> $past(acc_rd)); // R7
    AST_COMMIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || sfr_wr) |-> $past(acc_wr)); // R7
    AST_NONE_KIND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'b11) |-> (!ram_sel && !sfr_sel && !sfr_rd)); // R9
    AST_NONE_KIND_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'b11) |=> (!ram_we && !sfr_wr && !acc_rvalid)); // R9
endmodule

bind idm_decoder idm_checker #(.PSW_ADDR(PSW_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_addr    (acc_addr),
    .acc_indirect(acc_indirect),
    .acc_kind    (acc_kind),
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .acc_rvalid  (acc_rvalid),
    .ram_sel     (ram_sel),
    .sfr_sel     (sfr_sel),
    .ram_we      (ram_we),
    .bank_sel    (bank_sel),
    .sfr_raddr   (sfr_raddr),
    .sfr_rd      (sfr_rd),
    .sfr_waddr   (sfr_waddr),
    .sfr_wr      (sfr_wr)
);

// File: tb/sim_idm_decoder.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checks its own results.
module sim_idm_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_addr = '0;
    logic       acc_indirect = 1'b0;
    logic [1:0] acc_kind = 2'b00;
    logic       acc_rd = 1'b0;
    logic       acc_wr = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       acc_rvalid;
    logic       ram_sel, sfr_sel, ram_we;
    logic [1:0] bank_sel;
    logic [7:0] sfr_raddr, sfr_waddr, sfr_wdata;
    logic       sfr_rd, sfr_wr;
    logic [7:0] sfr_rdata;

    int checks = 0;
    int failures = 0;
    int status_bus_hits = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    idm_decoder u0 (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_indirect(acc_indirect),
        .acc_kind(acc_kind), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .ram_sel(ram_sel),
        .sfr_sel(sfr_sel), .ram_we(ram_we), .bank_sel(bank_sel),
        .sfr_raddr(sfr_raddr), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
        .sfr_waddr(sfr_waddr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata)
    );

    // External special-register model: a few implemented bytes, rest read 00h.
    logic [7:0] sfr_mem [256];
    function automatic bit sfr_impl(input logic [7:0] a);
        return a inside {8'h80, 8'h90, 8'hA0, 8'hA8, 8'hB0, 8'hE0, 8'hF0};
    endfunction
    assign sfr_rdata = sfr_impl(sfr_raddr) ? sfr_mem[sfr_raddr] : 8'h00;
    always @(posedge clk) begin
        if (sfr_wr && sfr_impl(sfr_waddr)) sfr_mem[sfr_waddr] <= sfr_wdata;
        if ((sfr_rd && sfr_raddr == 8'hD0) || (sfr_wr && sfr_waddr == 8'hD0))
            status_bus_hits <= status_bus_hits + 1;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one access for one cycle; caller then sees its results.
    task automatic drive(input logic [1:0] k, input logic ind, input logic [7:0] a,
                         input logic rd, input logic wr, input logic [7:0] d);
        acc_kind = k; acc_indirect = ind; acc_addr = a;
        acc_rd = rd; acc_wr = wr; acc_wdata = d;
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0; acc_kind = 2'b00;
    endtask

    task automatic wr(input logic [1:0] k, input logic ind, input logic [7:0] a,
                      input logic [7:0] d);
        drive(k, ind, a, 1'b0, 1'b1, d);
    endtask

    task automatic rd(input logic [1:0] k, input logic ind, input logic [7:0] a,
                      output logic [7:0] q);
        drive(k, ind, a, 1'b1, 1'b0, 8'h00);
        q = acc_rvalid ? acc_rdata : 8'hXX;
    endtask

    task automatic t_reset();
        check("R4 bank after reset", {6'b0, bank_sel}, 8'h00);
        check("R4 rvalid after reset", {7'b0, acc_rvalid}, 8'h00);
    endtask

    task automatic t_low_ram();
        logic [7:0] q;
        wr(2'b00, 1'b0, 8'h35, 8'hA5);
        @(negedge clk);
        rd(2'b00, 1'b1, 8'h35, q);
        check("R1 direct write indirect read", q, 8'hA5);
        wr(2'b00, 1'b1, 8'h7F, 8'h3C);
        @(negedge clk);
        rd(2'b00, 1'b0, 8'h7F, q);
        check("R1 indirect write direct read", q, 8'h3C);
    endtask

    task automatic t_high_split();
        logic [7:0] q;
        wr(2'b00, 1'b1, 8'hA0, 8'h11);
        wr(2'b00, 1'b0, 8'hA0, 8'h77);
        @(negedge clk);
        rd(2'b00, 1'b1, 8'hA0, q);
        check("R2 upper RAM untouched by SFR write", q, 8'h11);
        rd(2'b00, 1'b0, 8'hA0, q);
        check("R2 SFR holds direct write", q, 8'h77);
        wr(2'b00, 1'b1, 8'h9A, 8'h22);
        wr(2'b00, 1'b0, 8'h9A, 8'h55);
        @(negedge clk);
        rd(2'b00, 1'b1, 8'h9A, q);
        check("R10 unimplemented SFR write leaves RAM", q, 8'h22);
        rd(2'b00, 1'b0, 8'h9A, q);
        check("R10 unimplemented SFR read passes bus value", q, 8'h00);
        wr(2'b00, 1'b1, 8'hFF, 8'hEE);
        @(negedge clk);
        rd(2'b00, 1'b1, 8'hFF, q);
        check("R2 stack byte in upper RAM", q, 8'hEE);
    endtask

    task automatic t_regbank();
        logic [7:0] q;
        wr(2'b00, 1'b0, 8'hD0, 8'h00);
        wr(2'b10, 1'b0, 8'h03, 8'h13);
        @(negedge clk);
        rd(2'b00, 1'b1, 8'h03, q);
        check("R3 bank0 R3 at 03h", q, 8'h13);
        wr(2'b00, 1'b0, 8'hD0, 8'h18);
        @(negedge clk);
        check("R3 bank_sel after status write", {6'b0, bank_sel}, 8'h03);
        wr(2'b10, 1'b0, 8'h03, 8'h1B);
        @(negedge clk);
        rd(2'b00, 1'b0, 8'h1B, q);
        check("R3 bank3 R3 at 1Bh", q, 8'h1B);
        rd(2'b00, 1'b0, 8'h03, q);
        check("R3 bank0 byte untouched", q, 8'h13);
        rd(2'b00, 1'b0, 8'hD0, q);
        check("R3 status readback", q, 8'h18);
        check("R3 status never on external bus", status_bus_hits[7:0], 8'h00);
        wr(2'b00, 1'b0, 8'hD0, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_bit_ram();
        logic [7:0] q;
        wr(2'b00, 1'b0, 8'h2C, 8'hF0);
        @(negedge clk);
        wr(2'b01, 1'b0, 8'h62, 8'h01);
        @(negedge clk);
        wr(2'b01, 1'b0, 8'h67, 8'hFE);
        @(negedge clk);
        rd(2'b00, 1'b0, 8'h2C, q);
        check("R5 bit writes modify one bit each", q, 8'h74);
        rd(2'b01, 1'b0, 8'h62, q);
        check("R5 bit read set", q, 8'h01);
        rd(2'b01, 1'b0, 8'h63, q);
        check("R5 bit read clear", q, 8'h00);
    endtask

    task automatic t_bit_sfr();
        logic [7:0] q;
        wr(2'b00, 1'b0, 8'h90, 8'h81);
        @(negedge clk);
        wr(2'b01, 1'b0, 8'h95, 8'h01);
        @(negedge clk);
        rd(2'b00, 1'b0, 8'h90, q);
        check("R6 SFR bit write", q, 8'hA1);
        wr(2'b01, 1'b0, 8'hD3, 8'h01);
        @(negedge clk);
        wr(2'b10, 1'b0, 8'h00, 8'h5E);
        @(negedge clk);
        rd(2'b00, 1'b1, 8'h08, q);
        check("R6 status bit selects bank1", q, 8'h5E);
        rd(2'b01, 1'b0, 8'hD3, q);
        check("R6 status bit read", q, 8'h01);
        wr(2'b00, 1'b0, 8'hD0, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_back2back();
        logic [7:0] q;
        wr(2'b00, 1'b0, 8'h40, 8'h81);
        rd(2'b00, 1'b0, 8'h40, q);
        check("R7 read right after write", q, 8'h81);
        wr(2'b00, 1'b0, 8'h20, 8'h00);
        wr(2'b01, 1'b0, 8'h00, 8'h01);
        wr(2'b01, 1'b0, 8'h01, 8'h01);
        wr(2'b01, 1'b0, 8'h07, 8'h01);
        rd(2'b00, 1'b0, 8'h20, q);
        check("R7 chained bit writes forwarded", q, 8'h83);
        wr(2'b00, 1'b0, 8'hD0, 8'h10);
        wr(2'b10, 1'b0, 8'h05, 8'h77);
        @(negedge clk);
        rd(2'b00, 1'b0, 8'h15, q);
        check("R8 bank switch seen next cycle", q, 8'h77);
        wr(2'b00, 1'b0, 8'hD0, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_reserved();
        logic [7:0] q;
        wr(2'b00, 1'b0, 8'h50, 8'h12);
        @(negedge clk);
        wr(2'b11, 1'b0, 8'h50, 8'hFF);
        @(negedge clk);
        drive(2'b11, 1'b0, 8'h50, 1'b1, 1'b0, 8'h00);
        check("R9 no rvalid for kind 11", {7'b0, acc_rvalid}, 8'h00);
        rd(2'b00, 1'b0, 8'h50, q);
        check("R9 kind 11 write ignored", q, 8'h12);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) sfr_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_ram();
        t_high_split();
        t_regbank();
        t_bit_ram();
        t_bit_sfr();
        t_back2back();
        t_reserved();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule